// File: doc/BRIEF.md
# Interrupt Status Read and Poll Port

This block is the third operation command and its read-back path for an eight-level interrupt controller. The controller's command port carries bytes of several kinds. This block accepts only a byte with bit 7 low, bit 4 low and bit 3 high, and ignores every other byte. An accepted command sets what later reads of the port return. A read gives the pending-request vector or the in-service vector. After a poll command it gives, for one read, a word that reports whether a request is pending and which level wins. The same command also turns special mask mode on or off.

The controller keeps the request and in-service vectors and the priority resolver, and it feeds them in. When a poll read finds a pending level, the block raises a one-cycle acknowledge with that level. The controller uses this pulse to mark the level in service and to drop its request.

Top module: `irq_status_port`

## Requirements
- R1: A write is taken as a command only if wr_data[7]=0, wr_data[4]=0 and wr_data[3]=1. Any other written byte changes no state of this block.
- R2: An accepted command with bit 1 set chooses the source for later plain reads: bit 0 = 0 gives req_vec, bit 0 = 1 gives isr_vec. This choice holds until it is changed.
- R3: An accepted command with bit 1 clear leaves the read source as it was.
- R4: An accepted command with bit 2 set arms a poll. The next read returns the poll word: bit 7 = win_valid, bits 6:3 = 0, bits 2:0 = win_level while a request is pending and 0 when none is.
- R5: An armed poll is consumed by exactly one read. Later reads use the register source again.
- R6: An accepted command with bit 6 set loads smm_on from bit 5. With bit 6 clear, smm_on keeps its value whatever bit 5 holds.
- R7: A poll read with win_valid high pulses ack_valid for that read cycle, with ack_level equal to the returned level. ack_valid stays low in all other cycles.
- R8: After reset the read source is req_vec, no poll is armed and smm_on is 0.
- R9: A command with both bit 2 and bit 1 set returns the poll word on the next read. The new register selection applies to the reads after that.
- R10: rd_data is combinational and valid in the cycle rd_en is high. A command written in a cycle takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Write strobe for the command port |
| wr_data | input | 8 | Byte written to the command port |
| rd_en | input | 1 | Read strobe for the port |
| req_vec | input | 8 | Pending-request vector |
| isr_vec | input | 8 | In-service vector |
| win_valid | input | 1 | Resolver has a winning request |
| win_level | input | 3 | Level of the winning request |
| rd_data | output | 8 | Read data |
| smm_on | output | 1 | Special mask mode active |
| ack_valid | output | 1 | Poll acknowledge pulse |
| ack_level | output | 3 | Level acknowledged by the poll |

## Verification
The assertions check on every cycle that smm_on holds without an enabled write and loads bit 5 with one, that an armed poll clears after its read, and that each acknowledge matches the level bits of the poll word. Only the bench scenarios can show the rest. These are the sticky register selection across writes that leave it alone, the rejection of wrongly encoded bytes, the poll word when no request is pending, and the precedence of a poll over a read-register request written in the same byte.

// File: rtl/irq_status_port.sv
module irq_status_port #(
  parameter int NLVL = 8,
  localparam int LW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  input  logic [NLVL-1:0] req_vec,
  input  logic [NLVL-1:0] isr_vec,
  input  logic            win_valid,
  input  logic [LW-1:0]   win_level,
  output logic [7:0]      rd_data,
  output logic            smm_on,
  output logic            ack_valid,
  output logic [LW-1:0]   ack_level
);
  logic cmd, sel_isr, poll_arm;
  logic [7:0] poll_word;

  assign cmd = wr_en && !wr_data[7] && !wr_data[4] && wr_data[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_isr  <= 1'b0;
      poll_arm <= 1'b0;
      smm_on   <= 1'b0;
    end else begin
      if (cmd && wr_data[1]) sel_isr <= wr_data[0];
      if (cmd && wr_data[6]) smm_on <= wr_data[5];
      if (cmd && wr_data[2]) poll_arm <= 1'b1;
      else if (rd_en)        poll_arm <= 1'b0;
    end
  end

  always_comb begin
    poll_word = 8'h00;
    poll_word[7] = win_valid;
    if (win_valid) poll_word[LW-1:0] = win_level;
  end

  assign rd_data   = poll_arm ? poll_word : (sel_isr ? 8'(isr_vec) : 8'(req_vec));
  assign ack_valid = rd_en && poll_arm && win_valid;
  assign ack_level = win_level;

  p_smm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd && wr_data[6]) |=> $stable(smm_on));
  p_smm_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && wr_data[6]) |=> (smm_on == $past(wr_data[5])));
  p_poll_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_arm && !(cmd && wr_data[2])) |=> !poll_arm);
  p_ack_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (rd_data[7] && rd_data[LW-1:0] == ack_level));
  p_ack_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> rd_en);
endmodule

// File: tb/irq_status_port_tb.sv
module irq_status_port_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, win_valid = 0;
  logic [7:0] wr_data = 0, req_vec = 8'hA5, isr_vec = 8'h3C;
  logic [2:0] win_level = 0;
  logic [7:0] rd_data;
  logic smm_on, ack_valid;
  logic [2:0] ack_level;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic exp_ack_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_status_port u_dut (.clk, .rst_n, .wr_en, .wr_data, .rd_en, .req_vec, .isr_vec,
    .win_valid, .win_level, .rd_data, .smm_on, .ack_valid, .ack_level);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] exp, input logic exp_ack, input string tag);
    @(posedge clk); #1 rd_en = 1;
    exp_q.push_back(exp); exp_ack_q.push_back(exp_ack); tag_q.push_back(tag);
    @(posedge clk); #1 rd_en = 0;
  endtask

  always @(negedge clk) if (rd_en && exp_q.size() > 0) begin
    automatic logic [7:0] e = exp_q.pop_front();
    automatic logic ea = exp_ack_q.pop_front();
    automatic string t = tag_q.pop_front();
    chk(rd_data == e, t, rd_data, e);
    chk(ack_valid == ea && (!ea || ack_level == e[2:0]), {t, " ack"}, ack_valid, ea);
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    chk(smm_on == 0, "R8 smm reset", smm_on, 0);
    rd(8'hA5, 0, "R8 reset source req");
    wr(8'h0B); rd(8'h3C, 0, "R2 select isr");
    wr(8'h08); rd(8'h3C, 0, "R3 selection kept");
    wr(8'h0A); rd(8'hA5, 0, "R2 select req");
    wr(8'h8B); rd(8'hA5, 0, "R1 D7 set ignored");
    wr(8'h1B); rd(8'hA5, 0, "R1 D4 set ignored");
    wr(8'h64); chk(smm_on == 0, "R1 D3 clear no smm", smm_on, 0);
    rd(8'hA5, 0, "R1 D3 clear no poll");
    wr(8'h68); chk(smm_on == 1, "R6 smm set", smm_on, 1);
    wr(8'h28); chk(smm_on == 1, "R6 D5 without D6 ignored", smm_on, 1);
    wr(8'h48); chk(smm_on == 0, "R6 smm clear", smm_on, 0);
    win_valid = 1; win_level = 3'd5;
    wr(8'h0C); rd(8'h85, 1, "R4 R7 poll word pending");
    rd(8'hA5, 0, "R5 poll one shot");
    win_valid = 0;
    wr(8'h0C); rd(8'h00, 0, "R4 poll none pending");
    win_valid = 1; win_level = 3'd3;
    wr(8'h0F); rd(8'h83, 1, "R9 poll wins");
    rd(8'h3C, 0, "R9 selection after poll");
    @(posedge clk); #1 wr_en = 1; wr_data = 8'h0A; rd_en = 1;
    exp_q.push_back(8'h3C); exp_ack_q.push_back(0); tag_q.push_back("R10 old source same cycle");
    @(posedge clk); #1 wr_en = 0; rd_en = 0;
    rd(8'hA5, 0, "R10 new source next cycle");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule